// File: doc/BRIEF.md
# Clock-Stretching CPU Memory Bridge

This block sits between an external 8-bit processor with a 16-bit address bus and a shared SRAM. It makes the SRAM look to the processor like fast private memory. The bridge makes the processor clock itself. It divides the system clock by five into two low phases followed by three high phases. It samples the processor's address, write data and read/write line at the end of the second low phase. It then serves the access during the high phases. The processor sees a 64 KiB window that starts at SRAM address zero, so its vector bytes live at the top of that window.

One 256-byte page of the processor's address space (page 2, addresses 0x0200 to 0x02FF) is not memory. A write there is never stored. Instead it is handed to a command executor over a valid/ready port. The low address byte becomes the command code and the data byte becomes the argument. `cmd_valid` stays high, with code and argument unchanged, until the executor returns `cmd_ready` in the same cycle; that cycle completes both the transfer and the command. A read of that page returns the executor's reply byte. The processor is never told to wait. Instead, the bridge freezes its own phase counter in the first low phase for as long as a command is pending or the shared-memory arbiter withholds `mem_ready`. This stretches the processor clock's low time.

After system reset the bridge holds the processor in reset while it supplies a slow clock for a fixed number of periods. It then releases reset and switches to the five-phase clock. The processor data bus is split into `cpu_din`, `cpu_dout` and the driver enable `cpu_oe`.

Top module: `cpu_bridge`

## Requirements
- R1: With no stall, each processor clock period lasts 5 system clocks: `cpu_clk` is low for 2 of them and high for 3.
- R2: Address, data and read/write are sampled at the end of the second low phase. Changes to these inputs during the high phases do not affect the access in progress.
- R3: A write outside page 2 pulses `sram_we` for exactly the first high phase. During that phase `sram_addr` holds the processor address zero-extended to SRAM width, and `sram_wdata` holds the write data.
- R4: A write inside page 2 causes no SRAM write. It raises `cmd_valid`, with `cmd_code` set to address bits [7:0] and `cmd_arg` set to the data. Both are held stable until a cycle with `cmd_valid` and `cmd_ready` both high.
- R5: A read outside page 2 pulses `sram_re` in the first high phase, with the address on `sram_addr`. The byte returned is presented on `cpu_dout` during the second and third high phases.
- R6: A read inside page 2 does not assert `sram_re` and returns `cmd_reply` on `cpu_dout`.
- R7: While `cmd_valid` is pending, or while `mem_ready` is low, `cpu_clk` stays low in the first low phase and the cycle does not advance.
- R8: During and after system reset, `cpu_rst_n` stays low and no memory or command activity occurs. `cpu_clk` runs at `SLOW_DIV` system clocks per period, high for the second half of each period, for exactly `BOOT_TICKS` periods. `cpu_rst_n` then rises in the same cycle that `cpu_clk` falls into the first low phase.
- R9: `cpu_oe` is high only in the second and third high phases of read cycles.
- R10: Processor addresses map one-to-one onto the base of the SRAM. The top bytes 0xFFFC/0xFFFD read back the values stored there, 0x00 and 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| cpu_clk | output | 1 | Generated processor clock |
| cpu_rst_n | output | 1 | Active-low processor reset |
| cpu_addr | input | CPU_AW | Processor address bus |
| cpu_rw | input | 1 | Processor read/write (1 = read) |
| cpu_din | input | DW | Processor write data |
| cpu_dout | output | DW | Read data toward the processor |
| cpu_oe | output | 1 | Data bus driver enable |
| mem_ready | input | 1 | Shared-memory grant from the arbiter |
| sram_addr | output | SRAM_AW | SRAM address |
| sram_wdata | output | DW | SRAM write data |
| sram_we | output | 1 | SRAM write strobe |
| sram_re | output | 1 | SRAM read strobe |
| sram_rdata | input | DW | SRAM read data (asynchronous) |
| cmd_valid | output | 1 | Command pending |
| cmd_ready | input | 1 | Executor accepts and completes the command |
| cmd_code | output | 8 | Command code (offset in page 2) |
| cmd_arg | output | DW | Command argument |
| cmd_reply | input | DW | Reply byte for page-2 reads |

## Verification
The hardest state to reach from the ports is a stretched cycle: the counter must sit in the first low phase while a command or a memory grant is outstanding. The processor model cannot see the phases directly. It recovers them from `cpu_clk` edges and counts the low system clocks of each period. The command stub answers after a programmable delay, and the bench drops `mem_ready` at the start of a low phase. A long low count then shows that the freeze happened. The bench also changes the address and data inputs once the high phase has begun, to show that the sampled values are used.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [2:0] {
    PH_LO0 = 3'd0,
    PH_LO1 = 3'd1,
    PH_HI0 = 3'd2,
    PH_HI1 = 3'd3,
    PH_HI2 = 3'd4
  } phase_t;

  function automatic logic phase_is_high(input phase_t p);
    return (p == PH_HI0) || (p == PH_HI1) || (p == PH_HI2);
  endfunction

  function automatic phase_t phase_step(input phase_t p, input logic hold);
    case (p)
      PH_LO0:  return hold ? PH_LO0 : PH_LO1;
      PH_LO1:  return PH_HI0;
      PH_HI0:  return PH_HI1;
      PH_HI1:  return PH_HI2;
      default: return PH_LO0;
    endcase
  endfunction

endpackage

// File: rtl/bridge_clkgen.sv
module bridge_clkgen
  import bridge_pkg::*;
#(
  parameter int SLOW_DIV   = 40,
  parameter int BOOT_TICKS = 4096
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hold,
  output phase_t phase,
  output logic   running,
  output logic   cpu_clk,
  output logic   cpu_rst_n
);
  localparam int DIV_W  = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int TICK_W = (BOOT_TICKS > 1) ? $clog2(BOOT_TICKS) : 1;
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(SLOW_DIV - 1);
  localparam logic [DIV_W-1:0]  DIV_HALF  = DIV_W'(SLOW_DIV / 2);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(BOOT_TICKS - 1);

  logic [DIV_W-1:0]  div_q;
  logic [TICK_W-1:0] tick_q;
  phase_t            ph_nx;

  always_comb ph_nx = phase_step(phase, hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= '0;
      tick_q    <= '0;
      phase     <= PH_LO0;
      running   <= 1'b0;
      cpu_clk   <= 1'b0;
      cpu_rst_n <= 1'b0;
    end else if (!running) begin
      // boot: slow clock, processor held in reset
      if (div_q == DIV_LAST) begin
        div_q   <= '0;
        cpu_clk <= 1'b0;
        if (tick_q == TICK_LAST) begin
          running   <= 1'b1;
          cpu_rst_n <= 1'b1;
          phase     <= PH_LO0;
        end else begin
          tick_q <= tick_q + TICK_W'(1);
        end
      end else begin
        div_q   <= div_q + DIV_W'(1);
        cpu_clk <= (div_q + DIV_W'(1)) >= DIV_HALF;
      end
    end else begin
      phase   <= ph_nx;
      cpu_clk <= phase_is_high(ph_nx);
    end
  end

endmodule

// File: rtl/bridge_access.sv
module bridge_access
  import bridge_pkg::*;
#(
  parameter int             CPU_AW   = 16,
  parameter int             DW       = 8,
  parameter int             SRAM_AW  = 20,
  parameter logic [7:0]     CMD_PAGE = 8'h02
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               running,
  input  phase_t             phase,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic               cpu_rw,
  input  logic [DW-1:0]      cpu_din,
  input  logic [DW-1:0]      sram_rdata,
  input  logic [DW-1:0]      cmd_reply,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [DW-1:0]      sram_wdata,
  output logic               sram_we,
  output logic               sram_re,
  output logic [DW-1:0]      cpu_dout,
  output logic               cpu_oe,
  output logic               cmd_start,
  output logic [7:0]         cmd_code_in,
  output logic [DW-1:0]      cmd_arg_in
);
  localparam int PAD    = SRAM_AW - CPU_AW;
  localparam int PAGE_W = CPU_AW - 8;

  logic [CPU_AW-1:0] cap_addr;
  logic [DW-1:0]     cap_data;
  logic              cap_rw;
  logic              cap_win;
  logic [DW-1:0]     rd_q;
  logic              hi0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_data <= '0;
      cap_rw   <= 1'b1;
      cap_win  <= 1'b0;
      rd_q     <= '0;
    end else if (running) begin
      if (phase == PH_LO1) begin
        cap_addr <= cpu_addr;
        cap_data <= cpu_din;
        cap_rw   <= cpu_rw;
        cap_win  <= cpu_addr[CPU_AW-1:8] == PAGE_W'(CMD_PAGE);
      end
      if (phase == PH_HI0 && cap_rw)
        rd_q <= cap_win ? cmd_reply : sram_rdata;
    end
  end

  always_comb begin
    hi0         = running && (phase == PH_HI0);
    sram_addr   = {{PAD{1'b0}}, cap_addr};
    sram_wdata  = cap_data;
    sram_we     = hi0 && !cap_rw && !cap_win;
    sram_re     = hi0 &&  cap_rw && !cap_win;
    cmd_start   = hi0 && !cap_rw &&  cap_win;
    cmd_code_in = cap_addr[7:0];
    cmd_arg_in  = cap_data;
    cpu_oe      = running && cap_rw && (phase == PH_HI1 || phase == PH_HI2);
    cpu_dout    = rd_q;
  end

endmodule

// File: rtl/bridge_cmd.sv
module bridge_cmd #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    code_in,
  input  logic [DW-1:0] arg_in,
  input  logic          cmd_ready,
  output logic          cmd_valid,
  output logic [7:0]    cmd_code,
  output logic [DW-1:0] cmd_arg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      cmd_arg   <= '0;
    end else if (start) begin
      cmd_valid <= 1'b1;
      cmd_code  <= code_in;
      cmd_arg   <= arg_in;
    end else if (cmd_valid && cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cpu_bridge.sv
module cpu_bridge
  import bridge_pkg::*;
#(
  parameter int         CPU_AW     = 16,
  parameter int         DW         = 8,
  parameter int         SRAM_AW    = 20,
  parameter logic [7:0] CMD_PAGE   = 8'h02,
  parameter int         SLOW_DIV   = 40,
  parameter int         BOOT_TICKS = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               cpu_clk,
  output logic               cpu_rst_n,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic               cpu_rw,
  input  logic [DW-1:0]      cpu_din,
  output logic [DW-1:0]      cpu_dout,
  output logic               cpu_oe,
  input  logic               mem_ready,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [DW-1:0]      sram_wdata,
  output logic               sram_we,
  output logic               sram_re,
  input  logic [DW-1:0]      sram_rdata,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [7:0]         cmd_code,
  output logic [DW-1:0]      cmd_arg,
  input  logic [DW-1:0]      cmd_reply
);
  phase_t        phase;
  logic          running;
  logic          hold;
  logic          cmd_start;
  logic [7:0]    code_in;
  logic [DW-1:0] arg_in;

  assign hold = cmd_valid || !mem_ready;

  bridge_clkgen #(
    .SLOW_DIV  (SLOW_DIV),
    .BOOT_TICKS(BOOT_TICKS)
  ) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (hold),
    .phase    (phase),
    .running  (running),
    .cpu_clk  (cpu_clk),
    .cpu_rst_n(cpu_rst_n)
  );

  bridge_access #(
    .CPU_AW  (CPU_AW),
    .DW      (DW),
    .SRAM_AW (SRAM_AW),
    .CMD_PAGE(CMD_PAGE)
  ) u_access (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (running),
    .phase      (phase),
    .cpu_addr   (cpu_addr),
    .cpu_rw     (cpu_rw),
    .cpu_din    (cpu_din),
    .sram_rdata (sram_rdata),
    .cmd_reply  (cmd_reply),
    .sram_addr  (sram_addr),
    .sram_wdata (sram_wdata),
    .sram_we    (sram_we),
    .sram_re    (sram_re),
    .cpu_dout   (cpu_dout),
    .cpu_oe     (cpu_oe),
    .cmd_start  (cmd_start),
    .cmd_code_in(code_in),
    .cmd_arg_in (arg_in)
  );

  bridge_cmd #(
    .DW(DW)
  ) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cmd_start),
    .code_in  (code_in),
    .arg_in   (arg_in),
    .cmd_ready(cmd_ready),
    .cmd_valid(cmd_valid),
    .cmd_code (cmd_code),
    .cmd_arg  (cmd_arg)
  );

endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
  parameter int         CPU_AW   = 16,
  parameter int         DW       = 8,
  parameter int         SRAM_AW  = 20,
  parameter logic [7:0] CMD_PAGE = 8'h02
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_clk,
  input logic               cpu_rst_n,
  input logic               cpu_oe,
  input logic [SRAM_AW-1:0] sram_addr,
  input logic               sram_we,
  input logic               sram_re,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [7:0]         cmd_code,
  input logic [DW-1:0]      cmd_arg
);
  localparam int PAGE_W = CPU_AW - 8;

  // R1: a low phase is never shorter than two system clocks
  assert_low_min_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rst_n && $fell(cpu_clk)) |=> !cpu_clk);

  // R1: a high phase lasts three system clocks
  assert_high_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rst_n && $rose(cpu_clk)) |=> cpu_clk ##1 cpu_clk);

  // R3: SRAM writes only while the processor clock is high
  assert_we_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> (cpu_clk && cpu_rst_n));

  // R4: command page never reaches SRAM as a write
  assert_no_page_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> (sram_addr[CPU_AW-1:8] != PAGE_W'(CMD_PAGE)));

  // R4: pending command holds its payload until accepted
  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_arg)));

  // R7: a pending command keeps the processor clock low
  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rst_n && !cpu_clk && cmd_valid) |=> !cpu_clk);

  // R8: no activity while the processor is in reset
  assert_quiet_boot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rst_n |-> (!sram_we && !sram_re && !cmd_valid && !cpu_oe));

  // R9: driver enabled only in a high phase
  assert_oe_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_oe |-> cpu_clk);

endmodule

bind cpu_bridge bridge_checker #(
  .CPU_AW  (CPU_AW),
  .DW      (DW),
  .SRAM_AW (SRAM_AW),
  .CMD_PAGE(CMD_PAGE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_clk  (cpu_clk),
  .cpu_rst_n(cpu_rst_n),
  .cpu_oe   (cpu_oe),
  .sram_addr(sram_addr),
  .sram_we  (sram_we),
  .sram_re  (sram_re),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_code (cmd_code),
  .cmd_arg  (cmd_arg)
);

// File: tb/sim_cpu_bridge.sv
`timescale 1ns/1ps
module sim_cpu_bridge;
  localparam int SLOW_DIV   = 8;
  localparam int BOOT_TICKS = 6;
  localparam logic [7:0] REPLY = 8'h5E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_clk, cpu_rst_n;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rw = 1'b1;
  logic [7:0]  cpu_din = '0;
  logic [7:0]  cpu_dout;
  logic        cpu_oe;
  logic        mem_ready = 1'b1;
  logic [19:0] sram_addr;
  logic [7:0]  sram_wdata;
  logic        sram_we, sram_re;
  logic [7:0]  sram_rdata;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [7:0]  cmd_code, cmd_arg;
  logic [7:0]  cmd_reply = REPLY;

  always #5 clk = ~clk;

  cpu_bridge #(.SLOW_DIV(SLOW_DIV), .BOOT_TICKS(BOOT_TICKS)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n),
    .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .cpu_din(cpu_din),
    .cpu_dout(cpu_dout), .cpu_oe(cpu_oe), .mem_ready(mem_ready),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_we(sram_we),
    .sram_re(sram_re), .sram_rdata(sram_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_arg(cmd_arg),
    .cmd_reply(cmd_reply)
  );

  // SRAM stub: asynchronous read, synchronous write, 1 KiB folded
  logic [7:0] sram_mem [0:1023];
  assign sram_rdata = sram_mem[sram_addr[9:0]];
  always @(posedge clk) if (sram_we) sram_mem[sram_addr[9:0]] <= sram_wdata;

  // command executor stub: accepts after cmd_delay low-side clocks
  int cmd_delay = 0;
  int cmd_wait  = 0;
  always @(negedge clk) begin
    if (cmd_valid) begin
      if (cmd_wait >= cmd_delay) cmd_ready = 1'b1;
      else cmd_wait++;
    end else begin
      cmd_ready = 1'b0;
      cmd_wait  = 0;
    end
  end

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle observations
  int         lows;
  logic       hi_ok, we_h0, re_h0, oe_h0, oe_h1, oe_h2, cv_h1;
  logic [19:0] ad_h0, ad_h1;
  logic [7:0] wd_h0, do_h1, cc_h1, ca_h1;

  // entry: at a low-side sample inside the first low phase
  task automatic cpu_cycle(input logic [15:0] a, input logic rw,
                           input logic [7:0] d, input int mr_hold);
    cpu_addr = a; cpu_rw = rw; cpu_din = d;
    if (mr_hold > 0) mem_ready = 1'b0;
    lows = 1;
    forever begin
      @(negedge clk);
      if (mr_hold > 0 && lows >= mr_hold) mem_ready = 1'b1;
      if (cpu_clk) break;
      lows++;
    end
    we_h0 = sram_we; re_h0 = sram_re; ad_h0 = sram_addr;
    wd_h0 = sram_wdata; oe_h0 = cpu_oe;
    cpu_addr = ~a; cpu_din = ~d;
    @(negedge clk);
    oe_h1 = cpu_oe; do_h1 = cpu_dout; cv_h1 = cmd_valid;
    cc_h1 = cmd_code; ca_h1 = cmd_arg; ad_h1 = sram_addr;
    hi_ok = cpu_clk;
    @(negedge clk);
    oe_h2 = cpu_oe;
    hi_ok = hi_ok && cpu_clk;
    @(negedge clk);
    hi_ok = hi_ok && !cpu_clk;
  endtask

  // {addr, rw(1=read), write data, expected read}
  localparam logic [32:0] VECS [12] = '{
    {16'h0300, 1'b0, 8'hA5, 8'h00},
    {16'h0300, 1'b1, 8'h00, 8'hA5},
    {16'h01FF, 1'b0, 8'h3C, 8'h00},
    {16'h01FF, 1'b1, 8'h00, 8'h3C},
    {16'hFFFC, 1'b1, 8'h00, 8'h00},
    {16'hFFFD, 1'b1, 8'h00, 8'h03},
    {16'h0200, 1'b0, 8'h77, 8'h00},
    {16'h02FF, 1'b0, 8'h19, 8'h00},
    {16'h0300, 1'b1, 8'h00, 8'hA5},
    {16'h0280, 1'b1, 8'h00, REPLY},
    {16'h0000, 1'b0, 8'h5A, 8'h00},
    {16'h0000, 1'b1, 8'h00, 8'h5A}
  };

  logic [15:0] va;
  logic        vrw, vwin;
  logic [7:0]  vwd, vexp;
  int          rises, hi_w, cur_w;
  logic        prev_clk;

  initial begin
    for (int i = 0; i < 1024; i++) sram_mem[i] = 8'h00;
    sram_mem[10'h3FC] = 8'h00;
    sram_mem[10'h3FD] = 8'h03;

    // reset state (R8)
    repeat (3) @(negedge clk);
    chk(cpu_rst_n == 1'b0, "R8 cpu reset low in reset", cpu_rst_n, 0);
    chk(cpu_clk == 1'b0, "R8 cpu clock low in reset", cpu_clk, 0);
    chk(!sram_we && !sram_re && !cmd_valid && !cpu_oe, "R8 quiet in reset",
        {sram_we, sram_re, cmd_valid, cpu_oe}, 0);
    rst_n = 1'b1;

    // boot slow clock (R8)
    rises = 0; hi_w = 0; cur_w = 0; prev_clk = 1'b0;
    forever begin
      @(negedge clk);
      if (cpu_rst_n) break;
      if (cpu_clk) begin
        if (!prev_clk) rises++;
        cur_w++;
      end else begin
        if (prev_clk && hi_w == 0) hi_w = cur_w;
        cur_w = 0;
      end
      prev_clk = cpu_clk;
      if (rises > BOOT_TICKS + 2) break;
    end
    chk(rises == BOOT_TICKS, "R8 boot clock periods", rises, BOOT_TICKS);
    chk(hi_w == SLOW_DIV - SLOW_DIV / 2, "R8 boot clock high width", hi_w,
        SLOW_DIV - SLOW_DIV / 2);
    chk(cpu_rst_n && !cpu_clk, "R8 release into low phase", {cpu_rst_n, cpu_clk}, 2);

    // vector walk
    for (int i = 0; i < 12; i++) begin
      {va, vrw, vwd, vexp} = VECS[i];
      vwin = (va[15:8] == 8'h02);
      cpu_cycle(va, vrw, vwd, 0);
      chk(lows == 2, "R1 low phase length", lows, 2);
      chk(hi_ok, "R1 high phase length", hi_ok, 1);
      if (!vrw && !vwin) begin
        chk(we_h0 && ad_h0 == {4'h0, va} && wd_h0 == vwd, "R3 sram write",
            {we_h0, ad_h0, wd_h0}, {1'b1, 4'h0, va, vwd});
        chk(ad_h1 == {4'h0, va}, "R2 address held after sampling", ad_h1, va);
      end
      if (!vrw && vwin)
        chk(!we_h0 && cv_h1 && cc_h1 == va[7:0] && ca_h1 == vwd, "R4 command write",
            {we_h0, cv_h1, cc_h1, ca_h1}, {1'b0, 1'b1, va[7:0], vwd});
      if (vrw && !vwin) begin
        chk(re_h0 && ad_h0 == {4'h0, va}, "R5 sram read strobe", {re_h0, ad_h0},
            {1'b1, 4'h0, va});
        chk(do_h1 == vexp, (i == 4 || i == 5) ? "R10 vector byte" : "R5 read data",
            do_h1, vexp);
      end
      if (vrw && vwin)
        chk(!re_h0 && do_h1 == vexp, "R6 reply read", {re_h0, do_h1}, {1'b0, vexp});
      if (vrw)
        chk(!oe_h0 && oe_h1 && oe_h2, "R9 driver enable on read",
            {oe_h0, oe_h1, oe_h2}, 3'b011);
      else
        chk(!oe_h0 && !oe_h1 && !oe_h2, "R9 driver off on write",
            {oe_h0, oe_h1, oe_h2}, 0);
    end

    // memory-grant stall (R7)
    cpu_cycle(16'h0040, 1'b0, 8'h42, 5);
    chk(lows > 5, "R7 stall on mem_ready low", lows, 6);
    cpu_cycle(16'h0040, 1'b1, 8'h00, 0);
    chk(do_h1 == 8'h42, "R7 write after stall landed", do_h1, 8'h42);

    // slow command stall (R7)
    cmd_delay = 6;
    cpu_cycle(16'h0233, 1'b0, 8'hC3, 0);
    chk(cv_h1 && cc_h1 == 8'h33 && ca_h1 == 8'hC3, "R4 slow command payload",
        {cc_h1, ca_h1}, 16'h33C3);
    cpu_cycle(16'h0000, 1'b1, 8'h00, 0);
    chk(lows >= 6, "R7 stall on pending command", lows, 6);
    chk(do_h1 == 8'h5A, "R7 read after command stall", do_h1, 8'h5A);
    cmd_delay = 0;

    // command page left SRAM untouched (R4)
    chk(sram_mem[10'h200] == 8'h00 && sram_mem[10'h233] == 8'h00,
        "R4 command page not stored", sram_mem[10'h233], 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule